// File: doc/BRIEF.md
# MII Receive Nibble Deserializer

This block sits directly on the receive side of a 4-bit media-independent interface. It runs on the receive clock that the PHY supplies, which is 2.5 MHz at 10 Mbit/s and 25 MHz at 100 Mbit/s. While the receive-valid line is high, it watches the incoming nibbles for the start-of-frame delimiter. Every nibble before the delimiter is discarded, and the PHY may raise valid at any point in the preamble. After the delimiter, the block joins nibble pairs into bytes, with the first nibble taken as the low half. It emits each byte as a one-cycle beat that carries first, last and error markers.

When valid is low, the receive-error line has a different meaning: it says that the data lanes hold an out-of-band code. The block latches that code and pulses a strobe for it. CRC checking, address filtering and storage belong to the logic downstream.

The output is a stream with valid but no ready. A PHY cannot be stalled, so the sink must accept every beat in the cycle it appears. To place the last marker, the block holds back one completed byte. Each byte therefore appears one byte-time late, and the final byte appears in the cycle after valid falls.

Top module: `mii_rx_deser`

## Requirements
- R1: While `rx_dv` is high, nibbles up to and including the delimiter are discarded. The delimiter is a nibble 0x5 followed directly by a nibble 0xD. The nibble after the 0xD is the low half of the first output byte.
- R2: Each output byte is formed as `{second_nibble, first_nibble}`. Lane bit 0 of each nibble is its least significant bit.
- R3: `byte_first` is high only on the first byte emitted for a frame.
- R4: A frame ends at the first clock edge that samples `rx_dv` low. The frame's final byte is emitted in the cycle after that edge, with `byte_last` high. No other byte carries `byte_last`.
- R5: If `rx_er` was sampled high on any edge where `rx_dv` was high, `byte_rxerr` is high on that frame's last byte. This includes error cycles in the preamble.
- R6: If a frame ends with an odd number of nibbles after the delimiter, `byte_odd` is high on its last byte. The unpaired nibble is dropped.
- R7: On every edge that samples `rx_dv` low and `rx_er` high, the next cycle shows a one-cycle pulse on `oob_stb`, and `oob_code` latches `rx_nib`. `oob_false_carrier` pulses along with the strobe when the code is 0xE.
- R8: The delimiter is found whatever the preamble length, down to valid rising on the final 0x5. Back-to-back frames separated by a single idle cycle are each aligned afresh.
- R9: The output has no back-pressure. While a frame is running, bytes that are not last appear no more often than every second cycle.
- R10: During and after reset, `byte_valid` and `oob_stb` are low. A frame that ends with no complete byte after the delimiter emits nothing.
- R11: `byte_rxerr` and `byte_odd` are high only on a valid last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rx | input | 1 | PHY receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid from the PHY |
| rx_er | input | 1 | Receive error / out-of-band indicator |
| rx_nib | input | 4 | Receive data lanes, bit 0 least significant |
| byte_valid | output | 1 | One-cycle byte beat |
| byte_data | output | 8 | Assembled byte |
| byte_first | output | 1 | Beat is the first byte of its frame |
| byte_last | output | 1 | Beat is the final byte of its frame |
| byte_rxerr | output | 1 | Frame saw a receive-error cycle (last beat only) |
| byte_odd | output | 1 | Frame ended on an unpaired nibble (last beat only) |
| oob_stb | output | 1 | Out-of-band code pulse |
| oob_code | output | 4 | Last out-of-band code seen |
| oob_false_carrier | output | 1 | Out-of-band code was 0xE, with the strobe |

## Verification
Some rules are checked by the assertions on every cycle. Error and odd flags appear only on a last beat. A last beat follows an edge where valid was low. A data beat that is not last follows an edge where valid was high. Two such data beats are never back to back. Out-of-band pulses follow only idle error cycles and carry the false-carrier code correctly. Other behaviour depends on the values flowing through, and only the bench's scenarios can show it. These scenarios cover delimiter placement for several preamble lengths, the nibble order inside each byte, first/last placement across consecutive frames, error cycles in the preamble and in the payload, odd-length frames, and frames that end right after the delimiter. The bench's reference model predicts each of these and compares on every clock.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t data;
    logic  first;
    logic  last;
    logic  rx_err;
    logic  odd;
  } rx_beat_t;
endpackage

// File: rtl/mii_sfd_hunt.sv
module mii_sfd_hunt
  import mii_rx_pkg::*;
#(
  parameter nib_t PRE_CODE = 4'h5,
  parameter nib_t SFD_CODE = 4'hD
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dv,
  input  nib_t nib,
  output logic aligned
);
  logic saw_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned <= 1'b0;
      saw_pre <= 1'b0;
    end else if (!dv) begin
      aligned <= 1'b0;
      saw_pre <= 1'b0;
    end else if (!aligned) begin
      saw_pre <= (nib == PRE_CODE);
      if (saw_pre && nib == SFD_CODE) aligned <= 1'b1;
    end
  end
endmodule

// File: rtl/mii_nib_packer.sv
module mii_nib_packer
  import mii_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     dv,
  input  logic     er,
  input  logic     aligned,
  input  nib_t     nib,
  output logic     beat_vld,
  output rx_beat_t beat
);
  nib_t  lo_q;
  logic  half_q;
  byte_t pend_q;
  logic  pend_vld_q;
  logic  pend_first_q;
  logic  first_next_q;
  logic  err_seen_q;
  byte_t joined;

  assign joined = {nib, lo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q         <= '0;
      half_q       <= 1'b0;
      pend_q       <= '0;
      pend_vld_q   <= 1'b0;
      pend_first_q <= 1'b0;
      first_next_q <= 1'b1;
      err_seen_q   <= 1'b0;
      beat_vld     <= 1'b0;
      beat         <= '0;
    end else begin
      beat_vld <= 1'b0;
      if (dv) begin
        err_seen_q <= err_seen_q | er;
        if (aligned) begin
          if (!half_q) begin
            lo_q   <= nib;
            half_q <= 1'b1;
          end else begin
            half_q       <= 1'b0;
            pend_q       <= joined;
            pend_vld_q   <= 1'b1;
            pend_first_q <= first_next_q;
            first_next_q <= 1'b0;
            if (pend_vld_q) begin
              beat_vld <= 1'b1;
              beat     <= '{data: pend_q, first: pend_first_q,
                            last: 1'b0, rx_err: 1'b0, odd: 1'b0};
            end
          end
        end
      end else begin
        if (pend_vld_q) begin
          beat_vld <= 1'b1;
          beat     <= '{data: pend_q, first: pend_first_q,
                        last: 1'b1, rx_err: err_seen_q, odd: half_q};
        end
        pend_vld_q   <= 1'b0;
        half_q       <= 1'b0;
        err_seen_q   <= 1'b0;
        first_next_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mii_oob_decode.sv
module mii_oob_decode
  import mii_rx_pkg::*;
#(
  parameter nib_t FC_CODE = 4'hE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dv,
  input  logic er,
  input  nib_t nib,
  output logic stb,
  output nib_t code,
  output logic false_carrier
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb           <= 1'b0;
      code          <= '0;
      false_carrier <= 1'b0;
    end else begin
      stb           <= 1'b0;
      false_carrier <= 1'b0;
      if (!dv && er) begin
        stb           <= 1'b1;
        code          <= nib;
        false_carrier <= (nib == FC_CODE);
      end
    end
  end
endmodule

// File: rtl/mii_rx_deser.sv
module mii_rx_deser
  import mii_rx_pkg::*;
#(
  parameter nib_t PRE_CODE = 4'h5,
  parameter nib_t SFD_CODE = 4'hD,
  parameter nib_t FC_CODE  = 4'hE
) (
  input  logic              clk_rx,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic              rx_er,
  input  logic [NIB_W-1:0]  rx_nib,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] byte_data,
  output logic              byte_first,
  output logic              byte_last,
  output logic              byte_rxerr,
  output logic              byte_odd,
  output logic              oob_stb,
  output logic [NIB_W-1:0]  oob_code,
  output logic              oob_false_carrier
);
  logic     aligned;
  logic     beat_vld;
  rx_beat_t beat;

  mii_sfd_hunt #(.PRE_CODE(PRE_CODE), .SFD_CODE(SFD_CODE)) hunt_i (
    .clk(clk_rx), .rst_n(rst_n), .dv(rx_dv), .nib(rx_nib), .aligned(aligned)
  );

  mii_nib_packer pack_i (
    .clk(clk_rx), .rst_n(rst_n), .dv(rx_dv), .er(rx_er), .aligned(aligned),
    .nib(rx_nib), .beat_vld(beat_vld), .beat(beat)
  );

  mii_oob_decode #(.FC_CODE(FC_CODE)) oob_i (
    .clk(clk_rx), .rst_n(rst_n), .dv(rx_dv), .er(rx_er), .nib(rx_nib),
    .stb(oob_stb), .code(oob_code), .false_carrier(oob_false_carrier)
  );

  assign byte_valid = beat_vld;
  assign byte_data  = beat.data;
  assign byte_first = beat_vld & beat.first;
  assign byte_last  = beat_vld & beat.last;
  assign byte_rxerr = beat_vld & beat.rx_err;
  assign byte_odd   = beat_vld & beat.odd;
endmodule

// File: rtl/mii_rx_deser_chk.sv
module mii_rx_deser_chk (
  input logic       clk_rx,
  input logic       rst_n,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       byte_valid,
  input logic       byte_last,
  input logic       byte_rxerr,
  input logic       byte_odd,
  input logic       oob_stb,
  input logic [3:0] oob_code,
  input logic       oob_false_carrier
);
  assert_flags_on_last_R11: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (byte_rxerr || byte_odd) |-> (byte_valid && byte_last));

  assert_last_after_idle_R4: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (byte_valid && byte_last) |-> $past(!rx_dv));

  assert_mid_after_data_R1: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (byte_valid && !byte_last) |-> $past(rx_dv));

  assert_byte_spacing_R9: assert property (@(posedge clk_rx) disable iff (!rst_n)
    (byte_valid && !byte_last) |=> !(byte_valid && !byte_last));

  assert_oob_source_R7: assert property (@(posedge clk_rx) disable iff (!rst_n)
    oob_stb |-> $past(!rx_dv && rx_er));

  assert_false_carrier_R7: assert property (@(posedge clk_rx) disable iff (!rst_n)
    oob_false_carrier |-> (oob_stb && oob_code == 4'hE));
endmodule

bind mii_rx_deser mii_rx_deser_chk chk_i (
  .clk_rx(clk_rx), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er),
  .byte_valid(byte_valid), .byte_last(byte_last), .byte_rxerr(byte_rxerr),
  .byte_odd(byte_odd), .oob_stb(oob_stb), .oob_code(oob_code),
  .oob_false_carrier(oob_false_carrier)
);

// File: tb/mii_rx_deser_tb_top.sv
module mii_rx_deser_tb_top;
  logic       clk_rx = 1'b0;
  logic       rst_n  = 1'b0;
  logic       rx_dv  = 1'b0;
  logic       rx_er  = 1'b0;
  logic [3:0] rx_nib = 4'h0;
  logic       byte_valid, byte_first, byte_last, byte_rxerr, byte_odd;
  logic [7:0] byte_data;
  logic       oob_stb, oob_false_carrier;
  logic [3:0] oob_code;

  always #10 clk_rx = ~clk_rx;

  mii_rx_deser dut_i (
    .clk_rx(clk_rx), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_first(byte_first),
    .byte_last(byte_last), .byte_rxerr(byte_rxerr), .byte_odd(byte_odd),
    .oob_stb(oob_stb), .oob_code(oob_code), .oob_false_carrier(oob_false_carrier)
  );

  int checks = 0;
  int errors = 0;
  string scen = "R10";

  // reference model state
  bit hunting = 1;
  int prev_nib = -1;
  int nibq[$];
  int byteq[$];
  int emitted = 0;
  bit err_seen = 0;
  bit e_valid = 0, e_first = 0, e_last = 0, e_rxerr = 0, e_odd = 0;
  int e_data = 0;
  bit e_stb = 0, e_fc = 0;
  int e_code = 0;

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (scenario %s) got %0h expected %0h at %0t", req, scen, got, exp, $time);
    end
  endtask

  task automatic compare();
    chk(byte_valid == e_valid, "R1 valid", byte_valid, e_valid);
    if (e_valid && byte_valid) begin
      chk(byte_data == e_data[7:0], "R2 data", byte_data, e_data);
      chk(byte_first == e_first, "R3 first", byte_first, e_first);
      chk(byte_last == e_last, "R4 last", byte_last, e_last);
      chk(byte_rxerr == e_rxerr, "R5 rxerr", byte_rxerr, e_rxerr);
      chk(byte_odd == e_odd, "R6 odd", byte_odd, e_odd);
    end
    if (!e_valid) chk(!byte_rxerr && !byte_odd, "R11 flags", {byte_rxerr, byte_odd}, 0);
    chk(oob_stb == e_stb, "R7 strobe", oob_stb, e_stb);
    if (e_stb && oob_stb) begin
      chk(oob_code == e_code[3:0], "R7 code", oob_code, e_code);
      chk(oob_false_carrier == e_fc, "R7 false carrier", oob_false_carrier, e_fc);
    end
  endtask

  task automatic model(input bit dv, input bit er, input int d);
    e_valid = 0; e_last = 0; e_rxerr = 0; e_odd = 0; e_first = 0;
    e_stb = 0; e_fc = 0;
    if (dv) begin
      if (er) err_seen = 1;
      if (hunting) begin
        if (prev_nib == 5 && d == 13) hunting = 0;
        prev_nib = d;
      end else begin
        nibq.push_back(d);
        if (nibq.size() == 2) begin
          int b;
          b = nibq[0] + 16 * nibq[1];
          nibq.delete();
          if (byteq.size() == 1) begin
            e_valid = 1;
            e_data = byteq.pop_front();
            e_first = (emitted == 0);
            emitted++;
          end
          byteq.push_back(b);
        end
      end
    end else begin
      if (byteq.size() == 1) begin
        e_valid = 1;
        e_data = byteq.pop_front();
        e_first = (emitted == 0);
        e_last = 1;
        e_rxerr = err_seen;
        e_odd = (nibq.size() == 1);
      end
      byteq.delete(); nibq.delete();
      hunting = 1; prev_nib = -1; emitted = 0; err_seen = 0;
      if (er) begin
        e_stb = 1; e_code = d; e_fc = (d == 14);
      end
    end
  endtask

  task automatic cyc(input bit dv, input bit er, input int d);
    @(negedge clk_rx);
    compare();
    rx_dv = dv; rx_er = er; rx_nib = d[3:0];
    model(dv, er, d);
  endtask

  task automatic frame(input int pre, input int n, input int err_at, input int gap);
    int idx = 0;
    for (int i = 0; i < pre; i++) begin cyc(1, idx == err_at, 5); idx++; end
    cyc(1, idx == err_at, 13); idx++;
    for (int i = 0; i < n; i++) begin
      cyc(1, idx == err_at, int'($urandom_range(0, 15))); idx++;
    end
    for (int i = 0; i < gap; i++) cyc(0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_rx);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_rx);
    chk(!byte_valid && !oob_stb, "R10 reset", {byte_valid, oob_stb}, 0);
    rst_n = 1;
    cyc(0, 0, 0); cyc(0, 0, 0);
    scen = "R1";  frame(15, 16, -1, 3);            // full preamble, even payload
    scen = "R2";  frame(7, 20, -1, 2);
    scen = "R8";  frame(3, 10, -1, 2);             // valid rises mid preamble
    scen = "R8";  frame(1, 8, -1, 1);              // only one 0x5 before SFD
    scen = "R8";  frame(5, 6, -1, 1);              // back-to-back after one idle
    scen = "R8";  frame(2, 6, -1, 2);
    scen = "R5";  frame(6, 12, 10, 2);             // error in payload
    scen = "R5";  frame(6, 12, 2, 2);              // error in preamble
    scen = "R6";  frame(4, 9, -1, 2);              // odd nibble count
    scen = "R6";  frame(4, 11, 8, 2);              // odd and error together
    scen = "R10"; frame(4, 0, -1, 2);              // ends right after SFD
    scen = "R10"; frame(4, 1, 3, 2);               // single nibble only
    scen = "R7";  cyc(0, 1, 14); cyc(0, 0, 0);     // false carrier
    scen = "R7";  cyc(0, 1, 7); cyc(0, 1, 14); cyc(0, 0, 0);
    scen = "R9";  for (int k = 0; k < 20; k++) frame(int'($urandom_range(1, 15)),
                    int'($urandom_range(0, 40)), int'($urandom_range(0, 80)) - 20,
                    int'($urandom_range(1, 3)));
    scen = "R1";  cyc(1, 0, 13); cyc(1, 0, 5); cyc(1, 0, 13); cyc(1, 0, 3);
                  cyc(1, 0, 4); cyc(1, 0, 9); cyc(1, 0, 10); cyc(0, 0, 0); cyc(0, 0, 0);
    cyc(0, 0, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule